// File: doc/BRIEF.md
# Cache Data Memory with Processor and System Buses

This block is the data store of a cache. One storage array, 9 bits per word (a byte plus its parity bit), sits between two data buses: one toward the processor and one toward the system. Both buses share a single address. On every rising clock edge the block samples the address, both input words and five active-low controls: a write strobe, an input enable and an output enable for each bus.

From those controls it chooses one operation. It can read the array onto either bus or both. It can write the array from either bus. It can write from one bus while streaming the same word out of the other. It can also pass a word from one bus to the other without touching the array. Some combinations would make a bus drive and receive at the same time. The block rejects these with an error flag and does nothing else.

Each output bus is a registered data word with a drive flag that stands in for the tri-state pins. Its result becomes visible one cycle after the controls are sampled. The array depth is set by an address-width parameter.

Top module: `cache_dual_sram`

## Requirements
- R1: While rst_ni is low, and in the cycle after its release, pdrive_o, sdrive_o and err_o are 0 and both data outputs are zero. A reset that arrives between the sampling of an operation and its output cancels that output.
- R2: Controls, address and data are sampled on a rising edge N. The resulting outputs change at edge N+1 and hold until edge N+2. An array write sampled at N is committed at N+1.
- R3: With we_ni=1, pie_ni=1 and sie_ni=1, the word at the address is read out as follows. poe_ni=0, soe_ni=1 reads it onto the processor output only. poe_ni=1, soe_ni=0 reads it onto the system output only. Both enables low reads it onto both outputs.
- R4: With we_ni=0 and both output enables high, two write cases apply. pie_ni=0, sie_ni=1 writes pdata_i into the array. pie_ni=1, sie_ni=0 writes sdata_i into the array. Neither case drives an output.
- R5: we_ni=0, pie_ni=0, sie_ni=1, poe_ni=1, soe_ni=0 writes pdata_i into the array and also presents it on the system output.
- R6: we_ni=0, pie_ni=1, sie_ni=0, poe_ni=0, soe_ni=1 writes sdata_i into the array and also presents it on the processor output.
- R7: Two bypass transfers leave the array unchanged. we_ni=1, pie_ni=0, sie_ni=1, poe_ni=1, soe_ni=0 presents pdata_i on the system output. we_ni=1, pie_ni=1, sie_ni=0, poe_ni=0, soe_ni=1 presents sdata_i on the processor output.
- R8: Four cases perform no operation: both input enables low (any we_ni); we_ni=0 with both input enables high; we_ni=1 with all four enables high; and we_ni=1 with exactly one input enable low and both output enables high. A no-operation drives no output, raises no error and leaves the array unchanged.
- R9: Two combinations are errors: pie_ni=0 with poe_ni=0 while sie_ni=1, and sie_ni=0 with soe_ni=0 while pie_ni=1. Either one raises err_o for one cycle (with R2 timing), drives no output and does not write the array, whatever we_ni is.
- R10: A write sampled at edge N followed by a read of the same address sampled at edge N+1 returns the newly written word after edge N+2.
- R11: Whenever a drive flag is 0, its data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Shared word address |
| we_ni | input | 1 | Write strobe, active low |
| pie_ni | input | 1 | Processor bus input enable, active low |
| sie_ni | input | 1 | System bus input enable, active low |
| poe_ni | input | 1 | Processor bus output enable, active low |
| soe_ni | input | 1 | System bus output enable, active low |
| pdata_i | input | WORD_W | Processor bus input word |
| sdata_i | input | WORD_W | System bus input word |
| pdata_o | output | WORD_W | Processor bus output word |
| pdrive_o | output | 1 | Processor bus output is driven |
| sdata_o | output | WORD_W | System bus output word |
| sdrive_o | output | 1 | System bus output is driven |
| err_o | output | 1 | Contending control combination was sampled |

## Verification
The write-through and allocate-with-stream cases each do an array write and a cross-bus stream in the same cycle. Each is provoked with a distinct word and judged twice. The first check is that the opposite output carries the word one cycle later. The second is that a later read of the same address returns that word. The bypass transfers are judged the other way round: the streamed word must appear, and a later read must still return the older stored word.

// File: rtl/cds_pkg.sv
package cds_pkg;

  typedef enum logic [3:0] {
    M_NOP,
    M_RD_P,
    M_RD_S,
    M_RD_PS,
    M_WR_P,
    M_WR_S,
    M_WR_THRU,
    M_ALLOC_STRM,
    M_BYP_P2S,
    M_BYP_S2P,
    M_ERR
  } cds_mode_e;

  typedef struct packed {
    logic we_n;
    logic pie_n;
    logic sie_n;
    logic poe_n;
    logic soe_n;
  } cds_ctl_t;

endpackage

// File: rtl/cds_mode_dec.sv
module cds_mode_dec
  import cds_pkg::*;
(
  input  cds_ctl_t  ctl_i,
  output cds_mode_e mode_o
);

  always_comb begin
    mode_o = M_NOP;
    case ({ctl_i.pie_n, ctl_i.sie_n})
      2'b11: begin
        if (ctl_i.we_n) begin
          case ({ctl_i.poe_n, ctl_i.soe_n})
            2'b01:   mode_o = M_RD_P;
            2'b10:   mode_o = M_RD_S;
            2'b00:   mode_o = M_RD_PS;
            default: mode_o = M_NOP;
          endcase
        end
      end
      2'b01: begin  // processor bus is the source
        if (!ctl_i.poe_n)     mode_o = M_ERR;
        else if (ctl_i.soe_n) mode_o = ctl_i.we_n ? M_NOP : M_WR_P;
        else                  mode_o = ctl_i.we_n ? M_BYP_P2S : M_WR_THRU;
      end
      2'b10: begin  // system bus is the source
        if (!ctl_i.soe_n)     mode_o = M_ERR;
        else if (ctl_i.poe_n) mode_o = ctl_i.we_n ? M_NOP : M_WR_S;
        else                  mode_o = ctl_i.we_n ? M_BYP_S2P : M_ALLOC_STRM;
      end
      default: mode_o = M_NOP;
    endcase
  end

endmodule

// File: rtl/cds_array.sv
module cds_array #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

endmodule

// File: rtl/cds_port_out.sv
module cds_port_out #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              drive_o,
  output logic [WORD_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      data_o  <= '0;
    end else begin
      drive_o <= en_i;
      data_o  <= en_i ? data_i : '0;
    end
  end

endmodule

// File: rtl/cache_dual_sram.sv
module cache_dual_sram
  import cds_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic              pie_ni,
  input  logic              sie_ni,
  input  logic              poe_ni,
  input  logic              soe_ni,
  input  logic [WORD_W-1:0] pdata_i,
  input  logic [WORD_W-1:0] sdata_i,
  output logic [WORD_W-1:0] pdata_o,
  output logic              pdrive_o,
  output logic [WORD_W-1:0] sdata_o,
  output logic              sdrive_o,
  output logic              err_o
);

  localparam int NBUS  = 2;
  localparam int BUS_P = 0;
  localparam int BUS_S = 1;

  cds_ctl_t          ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] pdat_q, sdat_q;

  // input capture; reset value is the all-idle control word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '1;
      addr_q <= '0;
      pdat_q <= '0;
      sdat_q <= '0;
    end else begin
      ctl_q  <= {we_ni, pie_ni, sie_ni, poe_ni, soe_ni};
      addr_q <= addr_i;
      pdat_q <= pdata_i;
      sdat_q <= sdata_i;
    end
  end

  cds_mode_e mode;

  cds_mode_dec u_dec (
    .ctl_i  (ctl_q),
    .mode_o (mode)
  );

  logic              arr_we;
  logic [WORD_W-1:0] arr_wdata, arr_rdata;

  cds_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_arr (
    .clk_i   (clk_i),
    .we_i    (arr_we),
    .addr_i  (addr_q),
    .wdata_i (arr_wdata),
    .rdata_o (arr_rdata)
  );

  logic [NBUS-1:0]   out_en;
  logic [WORD_W-1:0] out_src [NBUS];
  logic [NBUS-1:0]   out_drv;
  logic [WORD_W-1:0] out_dat [NBUS];

  always_comb begin
    arr_we         = 1'b0;
    arr_wdata      = pdat_q;
    out_en         = '0;
    out_src[BUS_P] = arr_rdata;
    out_src[BUS_S] = arr_rdata;
    case (mode)
      M_RD_P:  out_en[BUS_P] = 1'b1;
      M_RD_S:  out_en[BUS_S] = 1'b1;
      M_RD_PS: out_en        = '1;
      M_WR_P:  arr_we        = 1'b1;
      M_WR_S: begin
        arr_we    = 1'b1;
        arr_wdata = sdat_q;
      end
      M_WR_THRU: begin
        arr_we         = 1'b1;
        out_en[BUS_S]  = 1'b1;
        out_src[BUS_S] = pdat_q;
      end
      M_ALLOC_STRM: begin
        arr_we         = 1'b1;
        arr_wdata      = sdat_q;
        out_en[BUS_P]  = 1'b1;
        out_src[BUS_P] = sdat_q;
      end
      M_BYP_P2S: begin
        out_en[BUS_S]  = 1'b1;
        out_src[BUS_S] = pdat_q;
      end
      M_BYP_S2P: begin
        out_en[BUS_P]  = 1'b1;
        out_src[BUS_P] = sdat_q;
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NBUS; g++) begin : g_bus
    cds_port_out #(.WORD_W(WORD_W)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (out_en[g]),
      .data_i  (out_src[g]),
      .drive_o (out_drv[g]),
      .data_o  (out_dat[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= (mode == M_ERR);
  end

  assign pdrive_o = out_drv[BUS_P];
  assign pdata_o  = out_dat[BUS_P];
  assign sdrive_o = out_drv[BUS_S];
  assign sdata_o  = out_dat[BUS_S];

endmodule

// File: rtl/cds_chk.sv
module cds_chk #(
  parameter int WORD_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_ni,
  input logic              pie_ni,
  input logic              sie_ni,
  input logic              poe_ni,
  input logic              soe_ni,
  input logic [WORD_W-1:0] pdata_i,
  input logic [WORD_W-1:0] sdata_i,
  input logic [WORD_W-1:0] pdata_o,
  input logic              pdrive_o,
  input logic [WORD_W-1:0] sdata_o,
  input logic              sdrive_o,
  input logic              err_o,
  input logic              arr_we
);

  logic in_hit, in_thru, in_alloc_strm, in_byp, in_err, in_nop;

  assign in_hit        = !we_ni && !pie_ni &&  sie_ni &&  poe_ni &&  soe_ni;
  assign in_thru       = !we_ni && !pie_ni &&  sie_ni &&  poe_ni && !soe_ni;
  assign in_alloc_strm = !we_ni &&  pie_ni && !sie_ni && !poe_ni &&  soe_ni;
  assign in_byp        =  we_ni && ((!pie_ni && sie_ni && poe_ni && !soe_ni) ||
                                    (pie_ni && !sie_ni && !poe_ni && soe_ni));
  assign in_err        = (!pie_ni && sie_ni && !poe_ni) || (pie_ni && !sie_ni && !soe_ni);
  assign in_nop        = (!pie_ni && !sie_ni) || (!we_ni && pie_ni && sie_ni);

  a_r4_hit_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_hit |=> arr_we);

  a_r5_thru_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_thru |-> ##2 (sdrive_o && !pdrive_o && sdata_o == $past(pdata_i, 2)));

  a_r6_alloc_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_alloc_strm |-> ##2 (pdrive_o && !sdrive_o && pdata_o == $past(sdata_i, 2)));

  a_r7_bypass_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_byp |=> !arr_we);

  a_r8_nop_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_nop |-> ##2 (!pdrive_o && !sdrive_o && !err_o));

  a_r9_err_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_err |=> !arr_we);

  a_r9_err_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_err |-> ##2 err_o);

  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!pdrive_o && !sdrive_o));

  a_r11_p_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdrive_o |-> (pdata_o == '0));

  a_r11_s_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdrive_o |-> (sdata_o == '0));

endmodule

bind cache_dual_sram cds_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_ni    (we_ni),
  .pie_ni   (pie_ni),
  .sie_ni   (sie_ni),
  .poe_ni   (poe_ni),
  .soe_ni   (soe_ni),
  .pdata_i  (pdata_i),
  .sdata_i  (sdata_i),
  .pdata_o  (pdata_o),
  .pdrive_o (pdrive_o),
  .sdata_o  (sdata_o),
  .sdrive_o (sdrive_o),
  .err_o    (err_o),
  .arr_we   (arr_we)
);

// File: tb/cache_dual_sram_tb.sv
module cache_dual_sram_tb;

  localparam int AW = 10;
  localparam int WW = 9;
  localparam int NV = 23;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          we_ni = 1'b1, pie_ni = 1'b1, sie_ni = 1'b1, poe_ni = 1'b1, soe_ni = 1'b1;
  logic [WW-1:0] pdata_i = '0, sdata_i = '0;
  logic [WW-1:0] pdata_o, sdata_o;
  logic          pdrive_o, sdrive_o, err_o;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  cache_dual_sram #(.ADDR_W(AW), .WORD_W(WW)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_ni    (we_ni),
    .pie_ni   (pie_ni),
    .sie_ni   (sie_ni),
    .poe_ni   (poe_ni),
    .soe_ni   (soe_ni),
    .pdata_i  (pdata_i),
    .sdata_i  (sdata_i),
    .pdata_o  (pdata_o),
    .pdrive_o (pdrive_o),
    .sdata_o  (sdata_o),
    .sdrive_o (sdrive_o),
    .err_o    (err_o)
  );

  // ctl = {we, pie, sie, poe, soe}, all active low
  typedef struct packed {
    logic [4:0]    ctl;
    logic [3:0]    addr;
    logic [WW-1:0] pd;
    logic [WW-1:0] sd;
    logic          pv;
    logic [WW-1:0] pq;
    logic          sv;
    logic [WW-1:0] sq;
    logic          err;
    logic [3:0]    req;
  } vec_t;

  localparam logic [$bits(vec_t)-1:0] VECS [NV] = '{
    {5'b00111, 4'd1, 9'h1A5, 9'h000, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd4}, // R4 write from processor
    {5'b11101, 4'd1, 9'h000, 9'h000, 1'b1, 9'h1A5, 1'b0, 9'h000, 1'b0, 4'd3}, // R3 processor read
    {5'b01011, 4'd2, 9'h000, 9'h05A, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd4}, // R4 write from system
    {5'b11110, 4'd2, 9'h000, 9'h000, 1'b0, 9'h000, 1'b1, 9'h05A, 1'b0, 4'd3}, // R3 system read
    {5'b11100, 4'd1, 9'h000, 9'h000, 1'b1, 9'h1A5, 1'b1, 9'h1A5, 1'b0, 4'd3}, // R3 dual read
    {5'b00110, 4'd3, 9'h0F3, 9'h000, 1'b0, 9'h000, 1'b1, 9'h0F3, 1'b0, 4'd5}, // R5 write-through
    {5'b11101, 4'd3, 9'h000, 9'h000, 1'b1, 9'h0F3, 1'b0, 9'h000, 1'b0, 4'd5}, // R5 stored
    {5'b01001, 4'd4, 9'h000, 9'h13C, 1'b1, 9'h13C, 1'b0, 9'h000, 1'b0, 4'd6}, // R6 allocate + stream
    {5'b11110, 4'd4, 9'h000, 9'h000, 1'b0, 9'h000, 1'b1, 9'h13C, 1'b0, 4'd6}, // R6 stored
    {5'b10110, 4'd1, 9'h0AA, 9'h000, 1'b0, 9'h000, 1'b1, 9'h0AA, 1'b0, 4'd7}, // R7 bypass to system
    {5'b11101, 4'd1, 9'h000, 9'h000, 1'b1, 9'h1A5, 1'b0, 9'h000, 1'b0, 4'd7}, // R7 array unchanged
    {5'b11001, 4'd2, 9'h000, 9'h155, 1'b1, 9'h155, 1'b0, 9'h000, 1'b0, 4'd7}, // R7 bypass to processor
    {5'b11110, 4'd2, 9'h000, 9'h000, 1'b0, 9'h000, 1'b1, 9'h05A, 1'b0, 4'd7}, // R7 array unchanged
    {5'b00000, 4'd1, 9'h0C3, 9'h03C, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd8}, // R8 both inputs low
    {5'b01100, 4'd1, 9'h0C3, 9'h03C, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd8}, // R8 write, no source
    {5'b10111, 4'd1, 9'h0C3, 9'h000, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd8}, // R8 no write, no output
    {5'b11011, 4'd2, 9'h000, 9'h1FF, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd8}, // R8 no write, no output
    {5'b00101, 4'd1, 9'h077, 9'h000, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 4'd9}, // R9 processor contention
    {5'b01010, 4'd2, 9'h000, 9'h066, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 4'd9}, // R9 system contention
    {5'b00100, 4'd1, 9'h077, 9'h000, 1'b0, 9'h000, 1'b0, 9'h000, 1'b1, 4'd9}, // R9 both oe low
    {5'b11100, 4'd1, 9'h000, 9'h000, 1'b1, 9'h1A5, 1'b1, 9'h1A5, 1'b0, 4'd9}, // R9 R8 addr1 intact
    {5'b11110, 4'd2, 9'h000, 9'h000, 1'b0, 9'h000, 1'b1, 9'h05A, 1'b0, 4'd9}, // R9 R8 addr2 intact
    {5'b11111, 4'd1, 9'h000, 9'h000, 1'b0, 9'h000, 1'b0, 9'h000, 1'b0, 4'd8}  // R8 all idle
  };

  task automatic drive(input logic [4:0] ctl, input logic [AW-1:0] a,
                       input logic [WW-1:0] pd, input logic [WW-1:0] sd);
    {we_ni, pie_ni, sie_ni, poe_ni, soe_ni} = ctl;
    addr_i  = a;
    pdata_i = pd;
    sdata_i = sd;
  endtask

  task automatic check_out(input string tag, input logic [2*WW+2:0] exp);
    logic [2*WW+2:0] act;
    act = {pdrive_o, pdata_o, sdrive_o, sdata_o, err_o};
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  localparam logic [2*WW+2:0] IDLE_OUT = '0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin : main
    vec_t v;
    repeat (3) @(negedge clk);
    check_out("R1 outputs in reset", IDLE_OUT);
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1 after release", IDLE_OUT);

    // table walk: apply, idle, sample two negedges later
    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VECS[i]);
      drive(v.ctl, AW'(v.addr), v.pd, v.sd);
      @(negedge clk);
      drive(5'b11111, '0, '0, '0);
      @(negedge clk);
      check_out($sformatf("R%0d R11 vector %0d", v.req, i),
                {v.pv, v.pq, v.sv, v.sq, v.err});
    end

    // R10 and R2: write then read the same address on consecutive edges
    drive(5'b00111, AW'(5), 9'h123, '0);
    @(negedge clk);
    drive(5'b11101, AW'(5), '0, '0);
    @(negedge clk);
    check_out("R2 read not visible yet", IDLE_OUT);
    drive(5'b11111, '0, '0, '0);
    @(negedge clk);
    check_out("R10 read after write", {1'b1, 9'h123, 1'b0, 9'h000, 1'b0});

    // R10: two writes back to back, then system read
    drive(5'b01011, AW'(5), '0, 9'h0E1);
    @(negedge clk);
    drive(5'b00111, AW'(5), 9'h1C7, '0);
    @(negedge clk);
    drive(5'b11110, AW'(5), '0, '0);
    @(negedge clk);
    drive(5'b11111, '0, '0, '0);
    @(negedge clk);
    check_out("R10 last write wins", {1'b0, 9'h000, 1'b1, 9'h1C7, 1'b0});

    // R2: output holds exactly one cycle
    @(negedge clk);
    check_out("R2 output cleared next cycle", IDLE_OUT);

    // R1: reset between sampling and output cancels the read
    drive(5'b11100, AW'(1), '0, '0);
    @(negedge clk);
    rst_ni = 1'b0;
    drive(5'b11111, '0, '0, '0);
    @(negedge clk);
    check_out("R1 reset cancels pending read", IDLE_OUT);
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1 idle after second release", IDLE_OUT);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule